// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a clocked host and an external byte-wide asynchronous static RAM. The host raises a read or a write request together with an address and, for a write, a data byte. The controller turns that request into a sequence of active-low chip-select, output-enable and write-strobe levels on the memory pins. The host sees a single-cycle completion pulse and, after a read, the captured byte.

Every phase length is computed from a clock-period parameter and a set of nanosecond timing parameters, and each division is rounded up. A read keeps chip select and output enable low for the address-access window and then samples the data pins. A write keeps output enable high throughout. It uses one address/select setup phase, a write-strobe pulse with the data driven, and one hold phase with the data still driven. The bus drivers switch on only after the memory has had its float time following the last output-enable low. Between accesses chip select is high, so the memory sits in its low-power standby.

Top module: `sram_ctrl`

## Requirements
- R1: While rst_ni is low, sram_ce_no, sram_oe_no and sram_we_no are 1, and sram_dq_oe_o and done_o are 0.
- R2: In idle, sram_ce_no is 1 (standby) and OE, WE and the drivers are inactive. A request is taken only in idle, and a request raised while an access is in progress has no effect on the memory.
- R3: A read holds CE low, OE low and WE high for RD_CYC = ceil(max(T_AA_NS, T_RC_NS)/CLK_PERIOD_NS) cycles. It samples sram_dq_i at the end of that window into rdata_o.
- R4: A write holds OE high for its whole duration. It has at least one setup cycle with CE low and WE high, then WE low for WE_CYC = ceil(max(T_PWE_NS, T_SD_NS, T_AW_NS)/CLK_PERIOD_NS) cycles, then one cycle with WE high and CE low.
- R5: sram_dq_oe_o is 1 only during the WE-low and hold phases, never while OE is low. It first rises at least HZ_CYC = ceil(T_HZ_NS/CLK_PERIOD_NS) cycles after OE last went high.
- R6: The address and write byte are latched when a request is taken. sram_addr_o and sram_dq_o stay at the latched values until the access ends, whatever the host inputs do.
- R7: done_o is high for exactly one cycle per access. rdata_o keeps the last read byte until the next read completes.
- R8: If rd_req_i and wr_req_i are both high in an idle cycle, the read is performed and the write is dropped.
- R9: With a 4 ns clock and the default timing, done_o appears 4 cycles after a read request and 5 cycles after a write request issued on an idle bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_req_i | input | 1 | Read request, sampled in idle |
| wr_req_i | input | 1 | Write request, sampled in idle |
| addr_i | input | ADDR_W | Request address |
| wdata_i | input | DATA_W | Write byte |
| rdata_o | output | DATA_W | Last read byte |
| done_o | output | 1 | One-cycle completion pulse |
| sram_addr_o | output | ADDR_W | Memory address pins |
| sram_ce_no | output | 1 | Chip select, active low |
| sram_oe_no | output | 1 | Output enable, active low |
| sram_we_no | output | 1 | Write strobe, active low |
| sram_dq_o | output | DATA_W | Data driven toward memory |
| sram_dq_oe_o | output | 1 | Data driver enable |
| sram_dq_i | input | DATA_W | Data received from memory |

## Verification
Two things can fall in the same cycle. The first is a read request and a write request raised together in idle. The second is the setup phase of a write and the bus-float wait left over from a read that has just finished. The bench provokes the first by raising both strobes in one cycle with a new write byte, then reading the location back to confirm the stored byte is unchanged. It provokes the second by issuing a write on the very cycle a read completes. It judges the result from the lengthened setup phase, from the per-clock comparison of the driver enable against its model, and from the contention check on OE and the driver enable.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_WSET, ST_WPUL, ST_WHLD} st_e;

  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_ctrl_phase_cnt.sv
module sram_ctrl_phase_cnt #(
  parameter int unsigned W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/sram_ctrl_bus_guard.sv
module sram_ctrl_bus_guard #(
  parameter int unsigned HZ_CYC = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oe_n_i,
  output logic free_o
);
  localparam int unsigned HZ_MAX = (HZ_CYC < 1) ? 1 : HZ_CYC;
  localparam int unsigned HZ_W   = $clog2(HZ_MAX + 1);
  localparam logic [HZ_W-1:0] HZ_LD = HZ_W'(HZ_CYC);

  logic [HZ_W-1:0] wait_q;

  // reload while memory may drive, then count down float time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           wait_q <= '0;
    else if (!oe_n_i)      wait_q <= HZ_LD;
    else if (wait_q != '0) wait_q <= wait_q - 1'b1;
  end

  assign free_o = oe_n_i && (wait_q == '0);
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned T_AA_NS       = 10,
  parameter int unsigned T_RC_NS       = 10,
  parameter int unsigned T_PWE_NS      = 8,
  parameter int unsigned T_SD_NS       = 5,
  parameter int unsigned T_AW_NS       = 8,
  parameter int unsigned T_HZ_NS       = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_req_i,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic              sram_ce_no,
  output logic              sram_oe_no,
  output logic              sram_we_no,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);
  localparam int unsigned RD_RAW = max2(ns2cyc(T_AA_NS, CLK_PERIOD_NS), ns2cyc(T_RC_NS, CLK_PERIOD_NS));
  localparam int unsigned WE_RAW = max2(max2(ns2cyc(T_PWE_NS, CLK_PERIOD_NS),
                                             ns2cyc(T_SD_NS, CLK_PERIOD_NS)),
                                        ns2cyc(T_AW_NS, CLK_PERIOD_NS));
  localparam int unsigned RD_CYC = max2(RD_RAW, 1);
  localparam int unsigned WE_CYC = max2(WE_RAW, 1);
  localparam int unsigned HZ_CYC = ns2cyc(T_HZ_NS, CLK_PERIOD_NS);
  localparam int unsigned CNT_W  = $clog2(max2(RD_CYC, WE_CYC) + 1);
  localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WE_LD = CNT_W'(WE_CYC - 1);

  st_e              st_q, st_d;
  logic             cnt_load, cnt_last, bus_free;
  logic [CNT_W-1:0] cnt_val;
  logic             take, cap, done_d;
  logic             ce_n_q, oe_n_q, we_n_q, dq_oe_q, done_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  sram_ctrl_phase_cnt #(.W(CNT_W)) u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (cnt_load),
    .load_val_i(cnt_val),
    .last_o    (cnt_last)
  );

  sram_ctrl_bus_guard #(.HZ_CYC(HZ_CYC)) u_guard (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .oe_n_i(oe_n_q),
    .free_o(bus_free)
  );

  always_comb begin
    st_d     = st_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    take     = 1'b0;
    cap      = 1'b0;
    done_d   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (rd_req_i) begin
          st_d = ST_RD; take = 1'b1; cnt_load = 1'b1; cnt_val = RD_LD;
        end else if (wr_req_i) begin
          st_d = ST_WSET; take = 1'b1;
        end
      end
      ST_RD: if (cnt_last) begin
        st_d = ST_IDLE; cap = 1'b1; done_d = 1'b1;
      end
      ST_WSET: if (bus_free) begin
        st_d = ST_WPUL; cnt_load = 1'b1; cnt_val = WE_LD;
      end
      ST_WPUL: if (cnt_last) st_d = ST_WHLD;
      ST_WHLD: begin
        st_d = ST_IDLE; done_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // strobes come straight from flops fed by the next state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
      we_n_q  <= 1'b1;
      dq_oe_q <= 1'b0;
      done_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      st_q    <= st_d;
      ce_n_q  <= (st_d == ST_IDLE);
      oe_n_q  <= (st_d != ST_RD);
      we_n_q  <= (st_d != ST_WPUL);
      dq_oe_q <= (st_d == ST_WPUL) || (st_d == ST_WHLD);
      done_q  <= done_d;
      if (take) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
      if (cap) rdata_q <= sram_dq_i;
    end
  end

  assign rdata_o      = rdata_q;
  assign done_o       = done_q;
  assign sram_addr_o  = addr_q;
  assign sram_ce_no   = ce_n_q;
  assign sram_oe_no   = oe_n_q;
  assign sram_we_no   = we_n_q;
  assign sram_dq_o    = wdata_q;
  assign sram_dq_oe_o = dq_oe_q;
endmodule

// File: rtl/sram_ctrl_sva.sv
module sram_ctrl_sva
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 10,
  parameter int unsigned T_HZ_NS       = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              done_o,
  input logic [ADDR_W-1:0] sram_addr_o,
  input logic [DATA_W-1:0] sram_dq_o,
  input logic              sram_ce_no,
  input logic              sram_oe_no,
  input logic              sram_we_no,
  input logic              sram_dq_oe_o
);
  localparam int unsigned HZ_CYC = ns2cyc(T_HZ_NS, CLK_PERIOD_NS);

  int unsigned hi_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             hi_cnt <= HZ_CYC;
    else if (!sram_oe_no)    hi_cnt <= 0;
    else if (hi_cnt < HZ_CYC) hi_cnt <= hi_cnt + 1;
  end

  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_ce_no |-> (sram_oe_no && sram_we_no && !sram_dq_oe_o));

  a_r3_read_we_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_oe_no |-> sram_we_no);

  a_r4_write_oe_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> (sram_oe_no && !sram_ce_no));

  a_r5_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_no);

  a_r5_float_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_dq_oe_o) |-> (hi_cnt >= HZ_CYC));

  a_r6_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_ce_no && $past(!sram_ce_no)) |-> $stable(sram_addr_o));

  a_r6_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_dq_oe_o && $past(sram_dq_oe_o)) |-> $stable(sram_dq_o));

  a_r7_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind sram_ctrl sram_ctrl_sva #(
  .ADDR_W       (ADDR_W),
  .DATA_W       (DATA_W),
  .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .T_HZ_NS      (T_HZ_NS)
) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .done_o      (done_o),
  .sram_addr_o (sram_addr_o),
  .sram_dq_o   (sram_dq_o),
  .sram_ce_no  (sram_ce_no),
  .sram_oe_no  (sram_oe_no),
  .sram_we_no  (sram_we_no),
  .sram_dq_oe_o(sram_dq_oe_o)
);

// File: tb/sram_ctrl_tb_top.sv
module sram_ctrl_tb_top;
  localparam int CLK_NS = 4;
  localparam int RD_CYC = 3;   // ceil(10/4)
  localparam int WE_CYC = 2;   // ceil(8/4)
  localparam int HZ_CYC = 2;   // ceil(5/4)

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_req, wr_req;
  logic [18:0] addr;
  logic [7:0]  wdata;
  logic [7:0]  rdata;
  logic        done;
  logic [18:0] s_addr;
  logic        s_ce_n, s_oe_n, s_we_n, s_dq_oe;
  logic [7:0]  s_dq_o, s_dq_i;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_NS/2) clk = ~clk;

  sram_ctrl #(.CLK_PERIOD_NS(CLK_NS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rd_req_i(rd_req), .wr_req_i(wr_req),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .done_o(done),
    .sram_addr_o(s_addr), .sram_ce_no(s_ce_n), .sram_oe_no(s_oe_n),
    .sram_we_no(s_we_n), .sram_dq_o(s_dq_o), .sram_dq_oe_o(s_dq_oe),
    .sram_dq_i(s_dq_i)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // golden contents and memory pin model
  logic [7:0] gold [int];
  logic [7:0] mem  [int];
  logic       prev_we_n = 1'b1;

  function automatic logic [7:0] rd_gold(input logic [18:0] a);
    return gold.exists(int'(a)) ? gold[int'(a)] : 8'h00;
  endfunction
  function automatic logic [7:0] rd_mem(input logic [18:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'h00;
  endfunction

  // behavioural reference: phases as integers, float time as a cycle count
  int         m_ph, m_left, m_hi;
  logic       e_ce_n, e_oe_n, e_we_n, e_dq_oe, e_done;
  logic [18:0] m_addr;
  logic [7:0]  m_wdata, m_rd_exp, e_rdata;

  always @(posedge clk) begin : model
    int  nx;
    bit  hz_ok;
    if (!rst_n) begin
      m_ph = 0; m_left = 0; m_hi = HZ_CYC;
      e_ce_n = 1; e_oe_n = 1; e_we_n = 1; e_dq_oe = 0; e_done = 0;
      e_rdata = 8'h00; m_addr = '0; m_wdata = '0; m_rd_exp = '0;
    end else begin
      nx = m_ph;
      e_done = 0;
      hz_ok = e_oe_n && (m_hi >= HZ_CYC);
      if (!e_oe_n) m_hi = 0;
      else if (m_hi < HZ_CYC) m_hi++;
      case (m_ph)
        0: if (rd_req) begin
             nx = 1; m_left = RD_CYC; m_addr = addr; m_rd_exp = rd_gold(addr);
           end else if (wr_req) begin
             nx = 2; m_addr = addr; m_wdata = wdata; gold[int'(addr)] = wdata;
           end
        1: begin
             m_left--;
             if (m_left == 0) begin nx = 0; e_done = 1; e_rdata = m_rd_exp; end
           end
        2: if (hz_ok) begin nx = 3; m_left = WE_CYC; end
        3: begin m_left--; if (m_left == 0) nx = 4; end
        default: begin nx = 0; e_done = 1; end
      endcase
      m_ph    = nx;
      e_ce_n  = (nx == 0);
      e_oe_n  = (nx != 1);
      e_we_n  = (nx != 3);
      e_dq_oe = (nx == 3) || (nx == 4);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(s_ce_n == e_ce_n,   "R2", "ce_n",  s_ce_n,  e_ce_n);
      chk(s_oe_n == e_oe_n,   "R3", "oe_n",  s_oe_n,  e_oe_n);
      chk(s_we_n == e_we_n,   "R4", "we_n",  s_we_n,  e_we_n);
      chk(s_dq_oe == e_dq_oe, "R5", "dq_oe", s_dq_oe, e_dq_oe);
      chk(done == e_done,     "R7", "done",  done,    e_done);
      chk(rdata == e_rdata,   "R3", "rdata", rdata,   e_rdata);
      chk(!(s_dq_oe && !s_oe_n), "R5", "contention", s_dq_oe, 0);
      if (!s_ce_n) chk(s_addr == m_addr, "R6", "addr", s_addr, m_addr);
      if (s_dq_oe) chk(s_dq_o == m_wdata, "R6", "wdata", s_dq_o, m_wdata);
      if (s_we_n && !prev_we_n && !s_ce_n) begin
        chk(s_dq_oe, "R4", "data held at WE rise", s_dq_oe, 1);
        mem[int'(s_addr)] = s_dq_o;
      end
    end
    prev_we_n = s_we_n;
    s_dq_i = (!s_ce_n && !s_oe_n && s_we_n) ? rd_mem(s_addr) : 8'h5A;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <50000 cycles", cyc);
      finish_up();
    end
  end

  task automatic do_req(input bit r, input bit w, input logic [18:0] a,
                        input logic [7:0] d, output int n);
    rd_req = r; wr_req = w; addr = a; wdata = d;
    @(negedge clk);
    rd_req = 0; wr_req = 0; addr = ~a; wdata = ~d;  // R6: inputs move after accept
    n = 1;
    while (!done && n < 100) begin @(negedge clk); n++; end
  endtask

  initial begin
    int n;
    logic [7:0] held;
    rst_n = 0; rd_req = 0; wr_req = 0; addr = '0; wdata = '0; s_dq_i = 8'h5A;
    repeat (3) @(negedge clk);
    chk(s_ce_n && s_oe_n && s_we_n, "R1", "strobes in reset",
        {s_ce_n, s_oe_n, s_we_n}, 3'b111);
    chk(!s_dq_oe && !done, "R1", "dq_oe/done in reset", {s_dq_oe, done}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    do_req(0, 1, 19'h00012, 8'h3C, n);
    chk(n == WE_CYC + 3, "R9", "write latency idle bus", n, WE_CYC + 3);
    do_req(1, 0, 19'h00012, 8'h00, n);
    chk(n == RD_CYC + 1, "R9", "read latency", n, RD_CYC + 1);
    chk(rdata == 8'h3C, "R3", "readback", rdata, 8'h3C);

    for (int i = 0; i < 4; i++) begin
      logic [18:0] a;
      logic [7:0]  d;
      a = (i == 0) ? 19'h00000 : (i == 1) ? 19'h7FFFF : (i == 2) ? 19'h2AAAA : 19'h15555;
      d = 8'(i * 37 + 1);
      do_req(0, 1, a, d, n);
      do_req(1, 0, a, 8'h00, n);
      chk(rdata == d, "R3", "pattern readback", rdata, d);
      chk(rd_mem(a) == d, "R4", "memory content", rd_mem(a), d);
    end

    // write right after read: float wait stretches setup
    do_req(1, 0, 19'h00000, 8'h00, n);
    do_req(0, 1, 19'h00100, 8'h77, n);
    chk(n == HZ_CYC + WE_CYC + 2, "R5", "write latency after read", n, HZ_CYC + WE_CYC + 2);
    do_req(1, 0, 19'h00100, 8'h00, n);
    chk(rdata == 8'h77, "R5", "readback after turnaround", rdata, 8'h77);

    // simultaneous requests
    repeat (3) @(negedge clk);
    do_req(0, 1, 19'h00200, 8'h11, n);
    do_req(1, 1, 19'h00200, 8'hEE, n);
    chk(rdata == 8'h11, "R8", "read wins", rdata, 8'h11);
    do_req(1, 0, 19'h00200, 8'h00, n);
    chk(rdata == 8'h11, "R8", "write dropped", rdata, 8'h11);

    // request while busy is ignored
    rd_req = 1; addr = 19'h00012;
    @(negedge clk);
    rd_req = 0; wr_req = 1; addr = 19'h00300; wdata = 8'h99;
    @(negedge clk);
    wr_req = 0;
    while (!done) @(negedge clk);
    chk(rdata == 8'h3C, "R2", "busy read result", rdata, 8'h3C);
    do_req(1, 0, 19'h00300, 8'h00, n);
    chk(rdata == 8'h00, "R2", "busy write ignored", rdata, 8'h00);
    repeat (2) @(negedge clk);
    chk(s_ce_n, "R2", "standby in idle", s_ce_n, 1);

    // rdata held across a write
    held = rdata;
    do_req(0, 1, 19'h00400, 8'hC3, n);
    chk(rdata == held, "R7", "rdata held", rdata, held);
    @(negedge clk);
    chk(!done, "R7", "done single cycle", done, 0);

    repeat (4) @(negedge clk);
    finish_up();
  end
endmodule